// File: doc/BRIEF.md
# RGB to YCbCr Colour Converter

This block sits on a display pixel path and turns 24-bit RGB pixels into YCbCr. Each pixel arrives with a valid flag and a line-start flag. Depending on a per-pixel mode, the block does one of three things:

- passes the RGB word through untouched;
- emits a full 24-bit YCbCr triple;
- emits a 16-bit 4:2:2 stream in which each pixel carries its luma plus one chroma sample, alternating blue-difference and red-difference.

The conversion is a 3x3 signed matrix multiply with programmable coefficients, followed by a rounded division by 256, a per-channel offset and saturation to eight bits. Coefficients are 11-bit two's complement in units of 1/256. A typical full-range setup is:

| Output | R coefficient | G coefficient | B coefficient | Offset |
|--------|---------------|---------------|---------------|--------|
| Y      | 0x04c         | 0x096         | 0x01d         | 0      |
| Cb     | 0x7d5         | 0x7ac         | 0x080         | 0x080  |
| Cr     | 0x080         | 0x795         | 0x7ec         | 0x080  |

Coefficients and offsets are quasi-static register inputs. They may only change while no pixel is in flight.

Top module: `rgb2ycc_conv`

## Requirements
- R1: While rst_n is low, out_valid is 0 and out_data is 0.
- R2: Latency is fixed at 3 cycles. out_valid equals in_valid delayed by three clock edges, and each pixel's result appears in that same cycle.
- R3: With csc_mode 2'b00 (bypass), out_data equals the in_rgb word of the matching input pixel. in_rgb packs R in [23:16], G in [15:8] and B in [7:0].
- R4: With csc_mode 2'b01, out_data is {Y, Cb, Cr} with Y in [23:16], Cb in [15:8] and Cr in [7:0].
  - Output row n (0 = Y, 1 = Cb, 2 = Cr) computes R*k(3n) + G*k(3n+1) + B*k(3n+2).
  - Coefficient k(i) is the signed 11-bit field coef[11i+10:11i].
- R5: Each row sum S is rounded as floor((S + 128) / 256), so exact halves round upward, including for negative sums.
- R6: The offset for row n (signed 11-bit field offs[11n+10:11n]) is added after rounding. The result saturates to 0 when negative and to 255 when above 255.
- R7: With csc_mode 2'b10 (UYVY), out_data is {8'h00, chroma, Y}, with chroma in [15:8] and Y in [7:0]. Successive valid pixels alternate chroma between Cb and Cr.
- R8: A valid pixel with in_line_start high carries Cb, and the pixel after it carries Cr. The chroma phase advances on every valid pixel in every mode.
- R9: Cycles with in_valid low neither advance the chroma phase nor change out_data. out_data holds the last valid result.
- R10: csc_mode 2'b11 behaves as bypass.
- R11: The mode travels with each pixel, so a pixel-by-pixel change of csc_mode selects the output format of each individual pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_line_start | input | 1 | Marks the first pixel of a line |
| in_rgb | input | 3*CW | Pixel {R, G, B} |
| csc_mode | input | 2 | 00/11 bypass, 01 YCbCr, 10 UYVY |
| coef | input | 9*KW | Nine signed coefficients, row-major (Y, Cb, Cr rows; R, G, B columns) |
| offs | input | 3*KW | Signed offsets for Y, Cb, Cr |
| out_valid | output | 1 | Output pixel qualifier |
| out_data | output | 3*CW | Converted or passed-through pixel |

## Verification
The bench builds the block with its defaults: 8-bit channels, 11-bit coefficients and 8 fraction bits. At that size a 4096-point colour grid and full 0..255 ramps are cheap to run, so every rounding tie and both saturation limits are reached. Coefficient sets at the extremes of the signed range (+1023 and -1024), together with negative offsets, drive the sums well past both clamp bounds. UYVY lines of odd and even length, with idle gaps, exercise the phase restart and phase hold behaviour.

// File: rtl/rgb2ycc_pkg.sv
package rgb2ycc_pkg;

  typedef enum logic [1:0] {
    CSC_PASS     = 2'b00,
    CSC_YCC      = 2'b01,
    CSC_UYVY     = 2'b10,
    CSC_PASS_ALT = 2'b11
  } csc_mode_e;

  // Side information that travels alongside each pixel
  typedef struct packed {
    logic      vld;
    logic      sol;
    csc_mode_e mode;
  } csc_tag_t;

endpackage

// File: rtl/rgb2ycc_mul.sv
// Stage 1: nine signed products, registered.
module rgb2ycc_mul #(
  parameter int CW = 8,
  parameter int KW = 11,
  parameter int PW = CW + KW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [3*CW-1:0] rgb_i,
  input  logic [9*KW-1:0] coef_i,
  output logic [9*PW-1:0] prod_o
);

  logic [9*PW-1:0] prod_d;
  logic [9*PW-1:0] prod_q;

  for (genvar k = 0; k < 9; k++) begin : g_prod
    localparam int COL = k % 3;
    logic signed [CW:0]   px;
    logic signed [KW-1:0] kc;
    logic signed [PW-1:0] p;

    assign px = $signed({1'b0, rgb_i[(2-COL)*CW +: CW]});
    assign kc = $signed(coef_i[k*KW +: KW]);
    assign p  = px * kc;
    assign prod_d[k*PW +: PW] = p;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else if (en) begin
      prod_q <= prod_d;
    end
  end

  assign prod_o = prod_q;

endmodule

// File: rtl/rgb2ycc_acc.sv
// Stage 2: row sums, rounding, offset and saturation, registered.
module rgb2ycc_acc #(
  parameter int CW   = 8,
  parameter int KW   = 11,
  parameter int PW   = CW + KW + 1,
  parameter int FRAC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [9*PW-1:0] prod_i,
  input  logic [3*KW-1:0] offs_i,
  output logic [3*CW-1:0] ycc_o
);

  localparam int SW   = PW + 2;
  localparam int HALF = 1 << (FRAC - 1);
  localparam int MAXV = (1 << CW) - 1;

  logic [3*CW-1:0] ycc_d;
  logic [3*CW-1:0] ycc_q;

  for (genvar r = 0; r < 3; r++) begin : g_row
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] rnd;
    logic signed [SW-1:0] off;
    logic signed [SW-1:0] tot;
    logic        [CW-1:0] sat;

    assign sum = SW'($signed(prod_i[(3*r)*PW +: PW]))
               + SW'($signed(prod_i[(3*r+1)*PW +: PW]))
               + SW'($signed(prod_i[(3*r+2)*PW +: PW]));
    assign rnd = (sum + SW'(HALF)) >>> FRAC;
    assign off = SW'($signed(offs_i[r*KW +: KW]));
    assign tot = rnd + off;

    always_comb begin
      if (tot < 0) begin
        sat = '0;
      end else if (tot > SW'(MAXV)) begin
        sat = '1;
      end else begin
        sat = tot[CW-1:0];
      end
    end

    assign ycc_d[(2-r)*CW +: CW] = sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ycc_q <= '0;
    end else if (en) begin
      ycc_q <= ycc_d;
    end
  end

  assign ycc_o = ycc_q;

endmodule

// File: rtl/rgb2ycc_fmt.sv
// Stage 3: mode select, chroma phase and output packing, registered.
module rgb2ycc_fmt
  import rgb2ycc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld_i,
  input  logic            sol_i,
  input  csc_mode_e       mode_i,
  input  logic [3*CW-1:0] rgb_i,
  input  logic [3*CW-1:0] ycc_i,
  output logic            vld_o,
  output logic [3*CW-1:0] data_o
);

  logic            ph_q;
  logic            ph_d;
  logic            use_cr;
  logic            vld_q;
  logic [3*CW-1:0] data_d;
  logic [3*CW-1:0] data_q;
  logic [CW-1:0]   y_c;
  logic [CW-1:0]   cb_c;
  logic [CW-1:0]   cr_c;
  logic [CW-1:0]   chroma;

  assign y_c    = ycc_i[3*CW-1 -: CW];
  assign cb_c   = ycc_i[2*CW-1 -: CW];
  assign cr_c   = ycc_i[CW-1:0];
  assign use_cr = sol_i ? 1'b0 : ph_q;
  assign chroma = use_cr ? cr_c : cb_c;

  always_comb begin
    ph_d = ph_q;
    if (vld_i) begin
      ph_d = ~use_cr;
    end
    unique case (mode_i)
      CSC_YCC:  data_d = ycc_i;
      CSC_UYVY: data_d = {{CW{1'b0}}, chroma, y_c};
      default:  data_d = rgb_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      ph_q   <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        ph_q   <= ph_d;
        data_q <= data_d;
      end
    end
  end

  assign vld_o  = vld_q;
  assign data_o = data_q;

endmodule

// File: rtl/rgb2ycc_conv.sv
module rgb2ycc_conv
  import rgb2ycc_pkg::*;
#(
  parameter int CW   = 8,
  parameter int KW   = 11,
  parameter int FRAC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_line_start,
  input  logic [3*CW-1:0] in_rgb,
  input  logic [1:0]      csc_mode,
  input  logic [9*KW-1:0] coef,
  input  logic [3*KW-1:0] offs,
  output logic            out_valid,
  output logic [3*CW-1:0] out_data
);

  localparam int PW = CW + KW + 1;

  csc_tag_t        tag0;
  csc_tag_t        tag1_q;
  csc_tag_t        tag2_q;
  logic [3*CW-1:0] rgb1_q;
  logic [3*CW-1:0] rgb2_q;
  logic [9*PW-1:0] prod;
  logic [3*CW-1:0] ycc;

  always_comb begin
    tag0.vld  = in_valid;
    tag0.sol  = in_line_start;
    tag0.mode = csc_mode_e'(csc_mode);
  end

  // Tag and bypass data alignment registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag1_q <= '0;
      tag2_q <= '0;
      rgb1_q <= '0;
      rgb2_q <= '0;
    end else begin
      tag1_q <= tag0;
      tag2_q <= tag1_q;
      if (in_valid) begin
        rgb1_q <= in_rgb;
      end
      if (tag1_q.vld) begin
        rgb2_q <= rgb1_q;
      end
    end
  end

  rgb2ycc_mul #(.CW(CW), .KW(KW), .PW(PW)) i_mul (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (in_valid),
    .rgb_i  (in_rgb),
    .coef_i (coef),
    .prod_o (prod)
  );

  rgb2ycc_acc #(.CW(CW), .KW(KW), .PW(PW), .FRAC(FRAC)) i_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (tag1_q.vld),
    .prod_i (prod),
    .offs_i (offs),
    .ycc_o  (ycc)
  );

  rgb2ycc_fmt #(.CW(CW)) i_fmt (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (tag2_q.vld),
    .sol_i  (tag2_q.sol),
    .mode_i (tag2_q.mode),
    .rgb_i  (rgb2_q),
    .ycc_i  (ycc),
    .vld_o  (out_valid),
    .data_o (out_data)
  );

endmodule

// File: rtl/rgb2ycc_chk.sv
module rgb2ycc_chk #(
  parameter int CW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [3*CW-1:0] in_rgb,
  input logic [1:0]      csc_mode,
  input logic            out_valid,
  input logic [3*CW-1:0] out_data
);

  // Edges seen since reset release, saturating at 3
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= 2'd0;
    end else if (age != 2'd3) begin
      age <= age + 2'd1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!out_valid && out_data == '0); // R1
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R2

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_valid && ($past(csc_mode, 3) == 2'b00 || $past(csc_mode, 3) == 2'b11))
      |-> (out_data == $past(in_rgb, 3))); // R3

  AST_UYVY_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_valid && $past(csc_mode, 3) == 2'b10)
      |-> (out_data[3*CW-1:2*CW] == '0)); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && !out_valid) |-> $stable(out_data)); // R9

endmodule

bind rgb2ycc_conv rgb2ycc_chk #(.CW(CW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_rgb    (in_rgb),
  .csc_mode  (csc_mode),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/test_rgb2ycc_conv.sv
module test_rgb2ycc_conv;

  localparam int CW = 8;
  localparam int KW = 11;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic            in_line_start;
  logic [3*CW-1:0] in_rgb;
  logic [1:0]      csc_mode;
  logic [9*KW-1:0] coef;
  logic [3*KW-1:0] offs;
  logic            out_valid;
  logic [3*CW-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;

  // Expected-result pipeline (index 2 is the oldest)
  logic        ev[3];
  logic [23:0] ed[3];
  string       er[3];
  logic [23:0] hold_exp;
  bit          ph_cr;

  always #10 clk = ~clk;

  rgb2ycc_conv #(.CW(CW), .KW(KW), .FRAC(8)) i_rgb2ycc_conv (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_line_start (in_line_start),
    .in_rgb        (in_rgb),
    .csc_mode      (csc_mode),
    .coef          (coef),
    .offs          (offs),
    .out_valid     (out_valid),
    .out_data      (out_data)
  );

  function automatic int sx(input logic [10:0] v);
    return v[10] ? int'(v) - 2048 : int'(v);
  endfunction

  function automatic logic [7:0] chan_ref(input logic [23:0] px, input int row);
    int acc = 0;
    int q;
    for (int c = 0; c < 3; c++) begin
      acc += int'(px[(2-c)*8 +: 8]) * sx(coef[(row*3+c)*KW +: KW]);
    end
    q = ((acc + 128) >>> 8) + sx(offs[row*KW +: KW]);
    if (q < 0) q = 0;
    if (q > 255) q = 255;
    return q[7:0];
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [24:0] act, input logic [24:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: {valid,data} actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: compare the result due now, then drive the next input
  task automatic step(input bit v, input bit s, input logic [23:0] rgb,
                      input logic [1:0] m, input string tag);
    logic [7:0] y, cb, cr, ch;
    @(negedge clk);
    check(out_valid === ev[2] && out_data === ed[2], er[2],
          {out_valid, out_data}, {ev[2], ed[2]});
    in_valid      = v;
    in_line_start = s;
    in_rgb        = rgb;
    csc_mode      = m;
    if (v) begin
      y  = chan_ref(rgb, 0);
      cb = chan_ref(rgb, 1);
      cr = chan_ref(rgb, 2);
      if (s) begin
        ch    = cb;
        ph_cr = 1'b1;
      end else begin
        ch    = ph_cr ? cr : cb;
        ph_cr = !ph_cr;
      end
      case (m)
        2'b01:   hold_exp = {y, cb, cr};
        2'b10:   hold_exp = {8'h00, ch, y};
        default: hold_exp = rgb;
      endcase
    end
    ev[2] = ev[1]; ed[2] = ed[1]; er[2] = er[1];
    ev[1] = ev[0]; ed[1] = ed[0]; er[1] = er[0];
    ev[0] = v;     ed[0] = hold_exp;
    er[0] = v ? tag : "R9";
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 24'h0, 2'b00, "R9");
  endtask

  task automatic set_coef(input int k0, input int k1, input int k2,
                          input int k3, input int k4, input int k5,
                          input int k6, input int k7, input int k8,
                          input int o0, input int o1, input int o2);
    idle(3);
    coef = {11'(k8), 11'(k7), 11'(k6), 11'(k5), 11'(k4),
            11'(k3), 11'(k2), 11'(k1), 11'(k0)};
    offs = {11'(o2), 11'(o1), 11'(o0)};
  endtask

  task automatic set_default;
    set_coef('h04c, 'h096, 'h01d, 'h7d5, 'h7ac, 'h080, 'h080, 'h795, 'h7ec,
             'h000, 'h080, 'h080);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      ev[i] = 1'b0;
      ed[i] = '0;
      er[i] = "R1";
    end
    hold_exp      = '0;
    ph_cr         = 1'b0;
    rst_n         = 1'b0;
    in_valid      = 1'b0;
    in_line_start = 1'b0;
    in_rgb        = '0;
    csc_mode      = 2'b00;
    coef          = '0;
    offs          = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid === 1'b0 && out_data === '0, "R1",
          {out_valid, out_data}, 25'h0);
    @(negedge clk);
    rst_n = 1'b1;
    set_default();

    // R2: isolated pixels with gaps
    step(1'b1, 1'b0, 24'h123456, 2'b00, "R2");
    idle(4);
    step(1'b1, 1'b0, 24'hfedcba, 2'b01, "R2");
    idle(5);

    // R4: grid sweep with the default matrix
    for (int r = 0; r < 256; r += 17)
      for (int g = 0; g < 256; g += 17)
        for (int b = 0; b < 256; b += 17)
          step(1'b1, 1'b0, {8'(r), 8'(g), 8'(b)}, 2'b01, "R4");

    // R3 and R10: bypass in both encodings
    for (int i = 0; i < 512; i++)
      step(1'b1, 1'b0, 24'(i * 32'h009e3779), (i % 2 == 0) ? 2'b00 : 2'b11,
           (i % 2 == 0) ? "R3" : "R10");

    // R5: half-step ties (R/2, G/4, 3B/4)
    set_coef('h080, 0, 0, 0, 'h040, 0, 0, 0, 'h0c0, 0, 0, 0);
    for (int i = 0; i < 256; i++) begin
      step(1'b1, 1'b0, {8'(i), 8'(i), 8'(i)}, 2'b01, "R5");
      step(1'b1, 1'b0, {8'(i), 8'(255 - i), 8'(i ^ 'h5a)}, 2'b01, "R5");
    end
    // R5: negative ties (-R/2, -G/4, -3B/4) with offset lifting into range
    set_coef('h780, 0, 0, 0, 'h7c0, 0, 0, 0, 'h740, 'h0ff, 'h0ff, 'h0ff);
    for (int i = 0; i < 256; i++)
      step(1'b1, 1'b0, {8'(i), 8'(i), 8'(i)}, 2'b01, "R5");

    // R6: saturation at both ends
    set_coef('h3ff, 'h3ff, 'h3ff, 'h400, 'h400, 'h400, 'h100, 0, 0,
             'h000, 'h7ff, 'h7c0);
    for (int r = 0; r < 256; r += 51)
      for (int g = 0; g < 256; g += 51)
        for (int b = 0; b < 256; b += 51)
          step(1'b1, 1'b0, {8'(r), 8'(g), 8'(b)}, 2'b01, "R6");
    for (int i = 0; i < 256; i++)
      step(1'b1, 1'b0, {8'(i), 8'(i >> 1), 8'(255 - i)}, 2'b01, "R6");

    // R11: mode changes every pixel
    set_default();
    for (int i = 0; i < 256; i++)
      step(1'b1, 1'b0, 24'(i * 32'h00a5c3d7 + 7), 2'(i % 4), "R11");

    // R7, R8, R9: UYVY lines of varying length with idle gaps
    for (int ln = 0; ln < 12; ln++) begin
      for (int p = 0; p < 5 + ln; p++) begin
        if (p % 4 == 3) idle(1 + ln % 3);
        step(1'b1, p == 0, 24'((ln * 977 + p * 131) * 32'h00010307),
             2'b10, (p == 0) ? "R8" : "R7");
      end
      idle(2);
    end
    // R9: line-start on an idle cycle has no effect
    step(1'b1, 1'b1, 24'h80ff10, 2'b10, "R8");
    step(1'b0, 1'b1, 24'h000000, 2'b10, "R9");
    step(1'b1, 1'b0, 24'h10ff80, 2'b10, "R9");
    step(1'b1, 1'b0, 24'h336699, 2'b10, "R7");
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule